// File: doc/BRIEF.md
# Nibble-Stream Command Detector

This block watches a stream of 4-bit hex digits presented on slow switch-style inputs and drives one persistent indicator output. The producer places a digit on the data pins and raises a strobe. The strobe is asynchronous to the system clock. The block synchronizes the strobe and detects its rising transition. It registers the digit once for that transition and feeds it to a small matcher. The two-digit sequence A,B turns the indicator on. The sequence 5,0 turns it off. Every other digit sequence leaves it as it is.

Digits flow in only one direction. The strobe's rising edge is the only valid qualifier, and there is no ready signal and no back-pressure. The block accepts a digit on every strobe rising edge, provided the strobe stays low and then high for at least one clock each. A digit whose strobe pulse is shorter than that may be missed. The data pins must stay stable from the strobe's rising edge until three clock cycles later.

Top module: `nibcmd_detect`

## Requirements
- R1: A synchronous reset drives `led_o` to 0 and returns the matcher to idle. A digit received before the reset cannot combine with a digit received after it to form a command.
- R2: Each rising transition of `strobe_i` captures exactly one digit. Holding `strobe_i` high, or changing `data_i` while the strobe stays high, captures nothing further.
- R3: The digit 4'hA followed by the digit 4'hB (ON command) sets `led_o` to 1.
- R4: The digit 4'h5 followed by the digit 4'h0 (OFF command) sets `led_o` to 0.
- R5: Count as edge 1 the first rising clock edge at which `strobe_i` is sampled high for a digit that completes a command. `led_o` takes its new value at rising clock edge 4.
- R6: Matching overlaps. A repeated A stays armed for ON, so A,A,B is an ON command. A repeated 5 stays armed for OFF, so 5,5,0 is an OFF command.
- R7: A second digit that does not complete a command returns the matcher to idle. If that digit is A or 5, it starts a new command instead: A,5,0 turns the output off, 5,A,B turns it on, and A,3,B changes nothing.
- R8: A B or a 0 that arrives without its leading digit does nothing. `led_o` holds its value through any digits that form no command.
- R9: The digit is the raw level of `data_i`, with bit 3 as the most significant bit; a high bit is a 1. No inversion or decoding is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | 4 | Hex digit, raw switch levels |
| strobe_i | input | 1 | Asynchronous digit strobe; its rising edge marks a valid digit |
| led_o | output | 1 | Persistent command indicator |

## Verification
The assertions check these properties on every cycle:
- the reset value of the output and of the matcher;
- a capture pulse never lasts more than one cycle;
- the captured digit equals the data seen on the pulse;
- the output moves only on a captured digit, and moves the right way when a command completes;
- the matcher state that follows each kind of digit.

The bench's scenarios exercise what a single-cycle property cannot show:
- the four-edge latency from strobe to output;
- that a long-held strobe with changing data yields one digit only;
- the overlapping and restarting digit sequences;
- that a reset in the middle of a command discards the half-received command.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  typedef enum logic [1:0] {
    M_IDLE      = 2'd0,
    M_ARMED_ON  = 2'd1,
    M_ARMED_OFF = 2'd2
  } match_state_e;
endpackage

// File: rtl/nibcmd_strobe_sync.sv
// Synchronizes an asynchronous strobe and emits a one-cycle pulse on its rise.
module nibcmd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic fire_o
);
  localparam int LAST = STAGES;  // one extra flop holds the previous level

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[g] <= 1'b0;
          else       chain_q[g] <= strobe_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[g] <= 1'b0;
          else       chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign fire_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/nibcmd_capture.sv
// Registers the digit on the capture pulse and marks it valid for one cycle.
module nibcmd_capture #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               fire_i,
  input  logic [DIGIT_W-1:0] data_i,
  output logic               vld_o,
  output logic [DIGIT_W-1:0] digit_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_o   <= 1'b0;
      digit_o <= '0;
    end else begin
      vld_o <= fire_i;
      if (fire_i) digit_o <= data_i;
    end
  end
endmodule

// File: rtl/nibcmd_matcher.sv
// Two-digit overlapping matcher that sets or clears a persistent output.
module nibcmd_matcher
  import nibcmd_pkg::*;
#(
  parameter int               DIGIT_W    = 4,
  parameter logic [DIGIT_W-1:0] ON_FIRST   = 4'hA,
  parameter logic [DIGIT_W-1:0] ON_SECOND  = 4'hB,
  parameter logic [DIGIT_W-1:0] OFF_FIRST  = 4'h5,
  parameter logic [DIGIT_W-1:0] OFF_SECOND = 4'h0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               vld_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output match_state_e       state_o,
  output logic               led_o
);
  match_state_e state_q, state_n;
  logic         led_q, led_n;

  always_comb begin
    state_n = state_q;
    led_n   = led_q;
    if (vld_i) begin
      if (state_q == M_ARMED_ON && digit_i == ON_SECOND)   led_n = 1'b1;
      if (state_q == M_ARMED_OFF && digit_i == OFF_SECOND) led_n = 1'b0;
      if (digit_i == ON_FIRST)       state_n = M_ARMED_ON;
      else if (digit_i == OFF_FIRST) state_n = M_ARMED_OFF;
      else                           state_n = M_IDLE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= M_IDLE;
      led_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      led_q   <= led_n;
    end
  end

  assign state_o = state_q;
  assign led_o   = led_q;
endmodule

// File: rtl/nibcmd_detect.sv
module nibcmd_detect
  import nibcmd_pkg::*;
#(
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [DIGIT_W-1:0] data_i,
  input  logic               strobe_i,
  output logic               led_o
);
  logic               samp_pulse;
  logic               dig_vld;
  logic [DIGIT_W-1:0] dig_q;
  match_state_e       match_state;

  nibcmd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .strobe_i(strobe_i),
    .fire_o  (samp_pulse)
  );

  nibcmd_capture #(.DIGIT_W(DIGIT_W)) u_cap (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .fire_i (samp_pulse),
    .data_i (data_i),
    .vld_o  (dig_vld),
    .digit_o(dig_q)
  );

  nibcmd_matcher #(.DIGIT_W(DIGIT_W)) u_match (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .vld_i  (dig_vld),
    .digit_i(dig_q),
    .state_o(match_state),
    .led_o  (led_o)
  );
endmodule

// File: rtl/nibcmd_detect_chk.sv
module nibcmd_detect_chk
  import nibcmd_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [DIGIT_W-1:0] data_i,
  input logic               led_o,
  input logic               pulse,
  input logic               dig_vld,
  input logic [DIGIT_W-1:0] dig,
  input match_state_e       state
);
  logic rst_d_q = 1'b0;
  always @(posedge clk_i) rst_d_q <= rst_i;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_d_q |-> (led_o == 1'b0 && state == M_IDLE));

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse |=> !pulse);

  p_capture_data_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse |=> (dig_vld && dig == $past(data_i)));

  p_on_cmd_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (dig_vld && dig == 4'hB && state == M_ARMED_ON) |=> led_o);

  p_off_cmd_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (dig_vld && dig == 4'h0 && state == M_ARMED_OFF) |=> !led_o);

  p_hold_led_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !dig_vld |=> $stable(led_o));

  p_arm_on_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (dig_vld && dig == 4'hA) |=> state == M_ARMED_ON);

  p_arm_off_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (dig_vld && dig == 4'h5) |=> state == M_ARMED_OFF);

  p_back_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (dig_vld && dig != 4'hA && dig != 4'h5) |=> state == M_IDLE);
endmodule

bind nibcmd_detect nibcmd_detect_chk #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .data_i (data_i),
  .led_o  (led_o),
  .pulse  (samp_pulse),
  .dig_vld(dig_vld),
  .dig    (dig_q),
  .state  (match_state)
);

// File: tb/nibcmd_detect_bench.sv
module nibcmd_detect_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic [3:0] data = 4'h0;
  logic       led;

  int    vectors = 0;
  int    errors  = 0;
  bit    started = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // reference model state
  int hist[$];
  int mst  = 0;   // 0 idle, 1 after A, 2 after 5
  bit mled = 0;
  bit pv   = 0;
  int pd   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibcmd_detect u_nibcmd_detect (
    .clk_i(clk), .rst_i(rst), .data_i(data), .strobe_i(strobe), .led_o(led)
  );

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      hist = '{0, 0, 0};
      mst = 0; mled = 0; pv = 0; pd = 0;
    end else begin
      if (pv) begin
        if (pd == 'hB && mst == 1) mled = 1;
        if (pd == 'h0 && mst == 2) mled = 0;
        mst = (pd == 'hA) ? 1 : (pd == 'h5) ? 2 : 0;
      end
      pv = (hist[1] == 1 && hist[2] == 0);
      if (pv) pd = int'(data);
      hist.push_front(int'(strobe));
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (led !== mled) begin
        errors++;
        $display("FAIL %s: led=%0b expected %0b at %0t", cur_req, led, mled, $time);
      end
    end
  end

  task automatic check(input string req, input bit exp);
    vectors++;
    if (led !== exp) begin
      errors++;
      $display("FAIL %s: led=%0b expected %0b", req, led, exp);
    end
  endtask

  task automatic send(input logic [3:0] d, input int hold = 2);
    @(negedge clk);
    data = d; strobe = 1'b1;
    repeat (hold) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R8"; send(4'hB); check("R8", 1'b0); send(4'h0); check("R8", 1'b0);
    cur_req = "R3"; send(4'hA); send(4'hB); check("R3", 1'b1);
    cur_req = "R8"; send(4'h3); send(4'h7); send(4'hB); check("R8", 1'b1);
    cur_req = "R4"; send(4'h5); send(4'h0); check("R4", 1'b0);
    cur_req = "R6"; send(4'hA); send(4'hA); send(4'hB); check("R6", 1'b1);
    send(4'h5); send(4'h5); send(4'h0); check("R6", 1'b0);
    cur_req = "R7"; send(4'hA); send(4'hB); send(4'hA); send(4'h5); send(4'h0);
    check("R7", 1'b0);
    send(4'h5); send(4'hA); send(4'hB); check("R7", 1'b1);
    send(4'h5); send(4'h3); send(4'h0); check("R7", 1'b1);
    send(4'h5); send(4'h0); send(4'hA); send(4'h3); send(4'hB); check("R7", 1'b0);

    cur_req = "R2";
    send(4'hA, 20); send(4'hB, 1); check("R2", 1'b1);
    send(4'h5); send(4'h0);
    @(negedge clk); data = 4'hA; strobe = 1'b1;
    repeat (6) @(negedge clk); data = 4'hB;
    repeat (10) @(negedge clk); strobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", 1'b0);

    cur_req = "R5";
    send(4'hA);
    @(negedge clk); data = 4'hB; strobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R5", 1'b0);
    @(negedge clk);
    check("R5", 1'b1);
    strobe = 1'b0;
    repeat (4) @(negedge clk);

    cur_req = "R9"; send(4'h5); send(4'h4); send(4'h0); check("R9", 1'b1);
    send(4'h5); send(4'h1); check("R9", 1'b1);
    send(4'h5); send(4'h0); check("R9", 1'b0);
    send(4'hA); send(4'hF); check("R9", 1'b0);

    cur_req = "R1";
    send(4'hA);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    send(4'hB); check("R1", 1'b0);
    send(4'hA); send(4'hB);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule